// File: doc/BRIEF.md
# Segment Stream Framer

The block turns a series of captured segments into one self-describing word stream. Right after reset it sends a single stream header. The header carries the acquisition settings. After that, each segment goes out as a packet header, then its payload words, then a packet footer. Every meta record opens with a fixed magic word, a format version and a type code, so a reader can resynchronise anywhere in the stream. Each record is padded with zeros to a fixed number of words.

A segment opens with a start pulse. The pulse carries the timestamp of the first sample and the timestamp of the trigger, each as a 64-bit integer part and a 32-bit fraction. Samples then arrive over a valid/ready input. The block packs them little-end-first into output words and closes the segment when an end pulse arrives. The last partial word and the last partial block are filled with zero words. The footer repeats the packet header and adds the number of whole blocks the block actually sent, so segments that are variable or cut short can still be recovered. All output leaves through a valid/ready port that can be back-pressured.

Top module: `seg_stream_framer`

## Requirements
- R1: After reset the block emits exactly one stream header of SH_WORDS words (default 8). Record bit b sits in word b/W at bit b%W. The fields are:
  - magic 64'h5354_524D_4652_4D31 at bits 0..63
  - version at bits 64..71
  - type 0 at bits 72..73
  - input rate in MSa/s at bits 96..111
  - decimation power at bits 112..119
  - sample period in fs at bits 120..183
  - segment type at bits 184..185
  - infinite-length flag at bit 186
  - infinite-count flag at bit 187
  - zeros everywhere else
- R2: A start pulse taken while idle produces a packet header of PK_WORDS words (default 6). It holds the same magic and version, type 1 at bits 72..73, and zero at bits 96..159. It also holds:
  - data timestamp at bits 160..223
  - data fraction at bits 224..255
  - trigger timestamp at bits 256..319
  - trigger fraction at bits 320..351
  - zeros everywhere else
- R3: Sample k of a segment is placed in payload word k/(W/SW), at bits (k%(W/SW))*SW. Payload words follow the packet header in order.
- R4: After the end pulse, the unused lanes of the last word and any remaining words of the last block (BLK_WORDS words per block) go out as zeros.
- R5: The footer has the same layout as the packet header, with type 2 and the number of blocks sent at bits 96..159.
- R6: An end pulse that arrives before any sample produces a packet header and a footer with length 0, with no payload word between them.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged in the next cycle.
- R8: start_i has no effect unless the block is idle. end_i has no effect unless a packet header or payload is in progress.
- R9: samp_ready_o is high only during the payload phase, while no finished word is waiting and before the end pulse has been seen.
- R10: In the first cycle after reset is released, out_valid_o is high and carries stream header word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Segment start pulse |
| data_ts_i | input | 64 | Integer timestamp of first sample |
| data_frac_i | input | 32 | Fractional timestamp of first sample |
| trig_ts_i | input | 64 | Integer timestamp of trigger |
| trig_frac_i | input | 32 | Fractional timestamp of trigger |
| end_i | input | 1 | Segment end pulse |
| samp_valid_i | input | 1 | Sample valid |
| samp_data_i | input | SW | Sample value |
| samp_ready_o | output | 1 | Sample accepted when high with valid |
| rate_i | input | 16 | Input rate, MSa/s |
| dec_pow_i | input | 8 | Decimation power of two |
| period_i | input | 64 | Sample period, fs |
| seg_type_i | input | 2 | Segment type code |
| inf_len_i | input | 1 | Infinite segment length flag |
| inf_cnt_i | input | 1 | Infinite segment count flag |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | W | Output word |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The first packet-header word becomes valid one cycle after the start pulse is taken. A full payload word becomes valid one cycle after the sample that completes it. Each padding word becomes valid one cycle after the previous word is accepted, and the footer begins one cycle after the last block is closed. Because back-pressure stretches all of these delays, the scoreboard compares words in order at each accepted transfer rather than at fixed cycles. Fixed-cycle checks are kept for the stream header word right after reset and for word stability under a held-low ready.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [2:0] {ST_SHDR, ST_IDLE, ST_PHDR, ST_PAY, ST_FOOT} frm_state_e;

  localparam logic [1:0] KIND_STREAM = 2'd0;
  localparam logic [1:0] KIND_PKT    = 2'd1;
  localparam logic [1:0] KIND_FOOT   = 2'd2;

  localparam int OFS_MAGIC = 0;
  localparam int OFS_VER   = 64;
  localparam int OFS_KIND  = 72;
  localparam int OFS_RATE  = 96;
  localparam int OFS_DPOW  = 112;
  localparam int OFS_PER   = 120;
  localparam int OFS_STYPE = 184;
  localparam int OFS_INFL  = 186;
  localparam int OFS_INFC  = 187;
  localparam int OFS_LEN   = 96;
  localparam int OFS_DTS   = 160;
  localparam int OFS_DFR   = 224;
  localparam int OFS_TTS   = 256;
  localparam int OFS_TFR   = 320;
endpackage

// File: rtl/frm_meta_rec.sv
module frm_meta_rec
  import frm_pkg::*;
#(
  parameter int          W        = 64,
  parameter int          SH_WORDS = 8,
  parameter int          PK_WORDS = 6,
  parameter logic [63:0] MAGIC    = 64'h5354_524D_4652_4D31,
  parameter logic [7:0]  VERSION  = 8'h01,
  localparam int REC_WORDS = (SH_WORDS > PK_WORDS) ? SH_WORDS : PK_WORDS,
  localparam int REC_BITS  = REC_WORDS * W,
  localparam int IW        = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1
) (
  input  logic [1:0]    kind_i,
  input  logic [IW-1:0] widx_i,
  input  logic [15:0]   rate_i,
  input  logic [7:0]    dec_pow_i,
  input  logic [63:0]   period_i,
  input  logic [1:0]    seg_type_i,
  input  logic          inf_len_i,
  input  logic          inf_cnt_i,
  input  logic [63:0]   dts_i,
  input  logic [31:0]   dfr_i,
  input  logic [63:0]   tts_i,
  input  logic [31:0]   tfr_i,
  input  logic [63:0]   blocks_i,
  output logic [W-1:0]  word_o
);
  logic [REC_BITS-1:0] rec;

  always_comb begin
    rec = '0;
    rec[OFS_MAGIC +: 64] = MAGIC;
    rec[OFS_VER   +: 8]  = VERSION;
    rec[OFS_KIND  +: 2]  = kind_i;
    if (kind_i == KIND_STREAM) begin
      rec[OFS_RATE  +: 16] = rate_i;
      rec[OFS_DPOW  +: 8]  = dec_pow_i;
      rec[OFS_PER   +: 64] = period_i;
      rec[OFS_STYPE +: 2]  = seg_type_i;
      rec[OFS_INFL]        = inf_len_i;
      rec[OFS_INFC]        = inf_cnt_i;
    end else begin
      if (kind_i == KIND_FOOT) rec[OFS_LEN +: 64] = blocks_i;
      rec[OFS_DTS +: 64] = dts_i;
      rec[OFS_DFR +: 32] = dfr_i;
      rec[OFS_TTS +: 64] = tts_i;
      rec[OFS_TFR +: 32] = tfr_i;
    end
  end

  assign word_o = rec[int'(widx_i)*W +: W];
endmodule

// File: rtl/frm_pack.sv
module frm_pack #(
  parameter int W         = 64,
  parameter int SW        = 16,
  parameter int BLK_WORDS = 2,
  localparam int SPW = W / SW,
  localparam int LW  = (SPW > 1) ? $clog2(SPW) : 1,
  localparam int BWW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          end_seen_i,
  input  logic          samp_valid_i,
  input  logic [SW-1:0] samp_data_i,
  output logic          samp_ready_o,
  input  logic          out_ready_i,
  output logic          word_valid_o,
  output logic [W-1:0]  word_o,
  output logic          done_o,
  output logic [63:0]   blocks_o
);
  logic           full_q;
  logic [LW-1:0]  lane_q;
  logic [BWW-1:0] bw_q;
  logic [W-1:0]   acc_q;
  logic [63:0]    blocks_q;
  logic           pad_req, fire, tail_open;

  assign tail_open    = (lane_q != '0) || (bw_q != '0);
  assign samp_ready_o = en_i && !full_q && !end_seen_i;
  assign word_valid_o = en_i && full_q;
  assign pad_req      = en_i && end_seen_i && !full_q && tail_open;
  assign done_o       = en_i && end_seen_i && !full_q && !tail_open;
  assign fire         = word_valid_o && out_ready_i;
  assign word_o       = acc_q;
  assign blocks_o     = blocks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      lane_q   <= '0;
      bw_q     <= '0;
      acc_q    <= '0;
      blocks_q <= '0;
    end else if (clr_i) begin
      full_q   <= 1'b0;
      lane_q   <= '0;
      bw_q     <= '0;
      acc_q    <= '0;
      blocks_q <= '0;
    end else begin
      if (samp_ready_o && samp_valid_i) begin
        acc_q[int'(lane_q)*SW +: SW] <= samp_data_i;
        if (lane_q == LW'(SPW-1)) begin
          lane_q <= '0;
          full_q <= 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end else if (pad_req) begin
        lane_q <= '0;
        full_q <= 1'b1;
      end
      if (fire) begin
        full_q <= 1'b0;
        acc_q  <= '0;
        if (bw_q == BWW'(BLK_WORDS-1)) begin
          bw_q     <= '0;
          blocks_q <= blocks_q + 64'd1;
        end else begin
          bw_q <= bw_q + 1'b1;
        end
      end
    end
  end

  // a word closes early only once the segment end has been seen
  AST_PAD_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(full_q) && $past(lane_q) != LW'(SPW-1)) |-> $past(end_seen_i)); // R4

  AST_BLOCK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !clr_i && bw_q == BWW'(BLK_WORDS-1)) |=> blocks_q == $past(blocks_q) + 64'd1); // R5
endmodule

// File: rtl/seg_stream_framer.sv
module seg_stream_framer
  import frm_pkg::*;
#(
  parameter int          W         = 64,
  parameter int          SW        = 16,
  parameter int          BLK_WORDS = 2,
  parameter int          SH_WORDS  = 8,
  parameter int          PK_WORDS  = 6,
  parameter logic [63:0] MAGIC     = 64'h5354_524D_4652_4D31,
  parameter logic [7:0]  VERSION   = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [63:0]   data_ts_i,
  input  logic [31:0]   data_frac_i,
  input  logic [63:0]   trig_ts_i,
  input  logic [31:0]   trig_frac_i,
  input  logic          end_i,
  input  logic          samp_valid_i,
  input  logic [SW-1:0] samp_data_i,
  output logic          samp_ready_o,
  input  logic [15:0]   rate_i,
  input  logic [7:0]    dec_pow_i,
  input  logic [63:0]   period_i,
  input  logic [1:0]    seg_type_i,
  input  logic          inf_len_i,
  input  logic          inf_cnt_i,
  output logic          out_valid_o,
  output logic [W-1:0]  out_data_o,
  input  logic          out_ready_i
);
  localparam int REC_WORDS = (SH_WORDS > PK_WORDS) ? SH_WORDS : PK_WORDS;
  localparam int IW        = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;
  localparam int KW        = OFS_KIND / W;
  localparam int KB        = OFS_KIND % W;

  frm_state_e    state_q;
  logic [IW-1:0] widx_q;
  logic [63:0]   dts_q, tts_q;
  logic [31:0]   dfr_q, tfr_q;
  logic          end_seen_q;
  logic [1:0]    kind;
  logic          meta_last, meta_valid, fire, take_start;
  logic          pk_valid, pk_done;
  logic [W-1:0]  pk_word, meta_word;
  logic [63:0]   blocks;

  assign kind = (state_q == ST_SHDR) ? KIND_STREAM :
                (state_q == ST_FOOT) ? KIND_FOOT : KIND_PKT;
  assign meta_last  = (state_q == ST_SHDR) ? (widx_q == IW'(SH_WORDS-1))
                                           : (widx_q == IW'(PK_WORDS-1));
  assign meta_valid = (state_q == ST_SHDR) || (state_q == ST_PHDR) || (state_q == ST_FOOT);
  assign out_valid_o = meta_valid || pk_valid;
  assign out_data_o  = (state_q == ST_PAY) ? pk_word : meta_word;
  assign fire        = out_valid_o && out_ready_i;
  assign take_start  = (state_q == ST_IDLE) && start_i;

  frm_meta_rec #(
    .W(W), .SH_WORDS(SH_WORDS), .PK_WORDS(PK_WORDS), .MAGIC(MAGIC), .VERSION(VERSION)
  ) u_meta (
    .kind_i(kind), .widx_i(widx_q),
    .rate_i(rate_i), .dec_pow_i(dec_pow_i), .period_i(period_i),
    .seg_type_i(seg_type_i), .inf_len_i(inf_len_i), .inf_cnt_i(inf_cnt_i),
    .dts_i(dts_q), .dfr_i(dfr_q), .tts_i(tts_q), .tfr_i(tfr_q),
    .blocks_i(blocks), .word_o(meta_word)
  );

  frm_pack #(.W(W), .SW(SW), .BLK_WORDS(BLK_WORDS)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(take_start), .en_i(state_q == ST_PAY), .end_seen_i(end_seen_q),
    .samp_valid_i(samp_valid_i), .samp_data_i(samp_data_i), .samp_ready_o(samp_ready_o),
    .out_ready_i(out_ready_i), .word_valid_o(pk_valid), .word_o(pk_word),
    .done_o(pk_done), .blocks_o(blocks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SHDR;
      widx_q     <= '0;
      dts_q      <= '0;
      dfr_q      <= '0;
      tts_q      <= '0;
      tfr_q      <= '0;
      end_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SHDR: if (fire) begin
          widx_q <= meta_last ? '0 : widx_q + 1'b1;
          if (meta_last) state_q <= ST_IDLE;
        end
        ST_IDLE: if (start_i) begin
          dts_q      <= data_ts_i;
          dfr_q      <= data_frac_i;
          tts_q      <= trig_ts_i;
          tfr_q      <= trig_frac_i;
          end_seen_q <= 1'b0;
          widx_q     <= '0;
          state_q    <= ST_PHDR;
        end
        ST_PHDR: begin
          if (end_i) end_seen_q <= 1'b1;
          if (fire) begin
            widx_q <= meta_last ? '0 : widx_q + 1'b1;
            if (meta_last) state_q <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (end_i) end_seen_q <= 1'b1;
          if (pk_done) begin
            widx_q  <= '0;
            state_q <= ST_FOOT;
          end
        end
        ST_FOOT: if (fire) begin
          widx_q <= meta_last ? '0 : widx_q + 1'b1;
          if (meta_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R7

  AST_ONE_STREAM_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SHDR) |=> (state_q != ST_SHDR)); // R1

  AST_PKT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PHDR && widx_q == IW'(KW)) |-> out_data_o[KB +: 2] == KIND_PKT); // R2

  AST_FOOT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FOOT && widx_q == IW'(KW)) |-> out_data_o[KB +: 2] == KIND_FOOT); // R5

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(dts_q) && $stable(tts_q))); // R8

  AST_SAMP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_ready_o |-> (state_q == ST_PAY && !end_seen_q)); // R9
endmodule

// File: tb/tb_seg_stream_framer.sv
`timescale 1ns/1ps
module tb_seg_stream_framer;
  localparam logic [63:0] MAGIC = 64'h5354_524D_4652_4D31;
  localparam logic [7:0]  VER   = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, end_p = 1'b0, sv = 1'b0, out_ready = 1'b0;
  logic [63:0] dts = '0, tts = '0;
  logic [31:0] dfr = '0, tfr = '0;
  logic [15:0] sd = '0;
  logic samp_ready, out_valid;
  logic [63:0] out_data;
  logic [15:0] rate = 16'd10000;
  logic [7:0]  dpow = 8'd3;
  logic [63:0] per  = 64'd800;
  logic [1:0]  stype = 2'd1;
  logic inf_len = 1'b0, inf_cnt = 1'b1;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  logic bp_on = 1'b0, run_done = 1'b0, ready_en = 1'b0;
  logic prev_hold = 1'b0;
  logic [63:0] prev_data = '0;

  always #2.5 clk = ~clk;

  seg_stream_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_ts_i(dts), .data_frac_i(dfr),
    .trig_ts_i(tts), .trig_frac_i(tfr), .end_i(end_p), .samp_valid_i(sv),
    .samp_data_i(sd), .samp_ready_o(samp_ready), .rate_i(rate), .dec_pow_i(dpow),
    .period_i(per), .seg_type_i(stype), .inf_len_i(inf_len), .inf_cnt_i(inf_cnt),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_rec(input logic [1:0] kind, input logic [63:0] a_ts,
      input logic [31:0] a_fr, input logic [63:0] t_ts, input logic [31:0] t_fr,
      input logic [63:0] len);
    logic [511:0] r = '0;
    r[63:0] = MAGIC; r[71:64] = VER; r[73:72] = kind;
    if (kind == 2'd0) begin
      r[111:96] = rate; r[119:112] = dpow; r[183:120] = per;
      r[185:184] = stype; r[186] = inf_len; r[187] = inf_cnt;
    end else begin
      if (kind == 2'd2) r[159:96] = len;
      r[223:160] = a_ts; r[255:224] = a_fr; r[319:256] = t_ts; r[351:320] = t_fr;
    end
    return r;
  endfunction

  task automatic push_rec(input logic [1:0] kind, input logic [63:0] a_ts, input logic [31:0] a_fr,
      input logic [63:0] t_ts, input logic [31:0] t_fr, input logic [63:0] len, input string tag);
    logic [511:0] r = mk_rec(kind, a_ts, a_fr, t_ts, t_fr, len);
    for (int w = 0; w < ((kind == 2'd0) ? 8 : 6); w++) begin
      exp_q.push_back(r[w*64 +: 64]);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: transfer happens at the posedge following this negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) begin
        chk("R7 valid", {63'd0, out_valid}, 64'd1);
        chk("R7 data", out_data, prev_data);
      end
      prev_hold <= out_valid && !out_ready;
      prev_data <= out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("unexpected word", out_data, 64'hx);
        else chk(tag_q.pop_front(), out_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ready_en && (bp_on ? 1'($urandom % 2) : 1'b1);
    end
  end

  task automatic wait_drain();
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start(input logic [63:0] a, input logic [31:0] b,
      input logic [63:0] c, input logic [31:0] d);
    dts = a; dfr = b; tts = c; tfr = d; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_seg(input int n, input logic [15:0] base, input logic [63:0] a,
      input logic [31:0] b, input logic [63:0] c, input logic [31:0] d, input bit poke);
    int nblk = (n + 7) / 8;
    string mtag = (n == 0) ? "R6" : "R2";
    push_rec(2'd1, a, b, c, d, 64'd0, mtag);
    for (int wi = 0; wi < nblk * 2; wi++) begin
      logic [63:0] w = '0;
      for (int l = 0; l < 4; l++) if (wi*4 + l < n) w[l*16 +: 16] = base + 16'(wi*4 + l);
      exp_q.push_back(w);
      tag_q.push_back((wi*4 < n) ? "R3" : "R4");
    end
    push_rec(2'd2, a, b, c, d, 64'(nblk), (n == 0) ? "R6" : "R5");
    pulse_start(a, b, c, d);
    for (int k = 0; k < n; k++) begin
      if (poke && k == 3) begin
        sv = 1'b0;
        pulse_start(64'hDEAD, 32'hBEEF, 64'hFACE, 32'hCAFE); // R8 ignored mid-segment
      end
      sv = 1'b1; sd = base + 16'(k);
      @(negedge clk);
      while (!samp_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    sv = 1'b0;
    end_p = 1'b1;
    @(posedge clk); #1;
    end_p = 1'b0;
  endtask

  initial begin
    push_rec(2'd0, '0, '0, '0, '0, '0, "R1");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid", {63'd0, out_valid}, 64'd1);
    chk("R10 word0", out_data, MAGIC);
    chk("R9 idle", {63'd0, samp_ready}, 64'd0);
    @(posedge clk); #1;
    ready_en = 1'b1;
    wait_drain();
    run_seg(8, 16'h1000, 64'h11, 32'h22, 64'h33, 32'h44, 1'b0);
    wait_drain();
    run_seg(9, 16'h2000, 64'h0123_4567_89AB_CDEF, 32'h8000_0000, 64'h55, 32'h66, 1'b1);
    wait_drain();
    run_seg(0, 16'h0, 64'h77, 32'h88, 64'h99, 32'hAA, 1'b0);
    wait_drain();
    @(negedge clk);
    chk("R9 idle after footer", {63'd0, samp_ready}, 64'd0);
    @(posedge clk); #1;
    end_p = 1'b1; // R8: end while idle must not produce anything
    @(posedge clk); #1;
    end_p = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R8 idle end ignored", {63'd0, out_valid}, 64'd0);
    bp_on = 1'b1;
    run_seg(3, 16'h3000, 64'hAB, 32'hCD, 64'hEF, 32'h12, 1'b0);
    wait_drain();
    run_seg(17, 16'h4000, 64'h1, 32'h2, 64'h3, 32'h4, 1'b0);
    wait_drain();
    repeat (5) @(posedge clk);
    #1;
    chk("R5 trailing words", 64'(exp_q.size()), 64'd0);
    run_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule